// File: doc/BRIEF.md
# Two-Wire Bus Hot-Insertion Join Controller

This controller decides the moment at which the two-wire bus on a plug-in card may be tied to the bus of a live backplane. The card may be inserted, or powered up, while the backplane is in the middle of a transfer. Tying the two sides together at that point would corrupt the transfer, so the controller holds off. It stays in a lockout state while the supply is not good or the block is disabled, and it pays no attention to either bus during that time.

Once it is released from lockout, it watches the backplane lines. It waits either for a STOP condition or for a stretch of clock cycles in which both backplane lines stay high. When one of these events arrives and both card-side lines are high, it closes the pass path and turns on the rise-time accelerators in the same cycle. One cycle later it raises a ready flag.

All four bus lines enter through two-flop synchronisers. The supply-good and enable inputs are taken as synchronous levels.

Top module: `hs_join_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `link_o`, `accel_en_o` and `ready_o` are 0 and the controller is in lockout.
- R2: While `pwr_good` or `enable` is 0, the outputs stay 0 and no activity on any bus line leads to a connection, however long that activity lasts.
- R3: A STOP is a 0-to-1 change of backplane SDA while backplane SCL is 1. When a STOP arrives in the waiting state with both card lines at 1, `link_o` rises on the third rising clock edge after the SDA input changes, and not before.
- R4: In the waiting state, a run of IDLE_CYCLES consecutive cycles with both synchronised backplane lines at 1 is an idle event. The count starts from zero on leaving lockout, and any 0 on either line restarts it. When the lines are already high on leaving lockout, `link_o` rises on edge IDLE_CYCLES+1 after `enable` rises, and not on edge IDLE_CYCLES.
- R5: If a STOP or idle event arrives while either card line is 0, no connection is made. Card lines rising afterwards do not connect on their own; a fresh STOP or idle event is needed.
- R6: `accel_en_o` equals `link_o` in every cycle.
- R7: `ready_o` rises exactly one cycle after `link_o` rises, and only while `link_o` is 1.
- R8: Deasserting `pwr_good` or `enable` in the waiting or connected state drives `link_o`, `accel_en_o` and `ready_o` to 0 on the next edge and returns the controller to lockout. After it leaves lockout again, the idle count starts over.
- R9: A rise of backplane SDA while backplane SCL is 0 is not a STOP and does not connect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply above lockout threshold (synchronous level) |
| enable | input | 1 | Block enable (synchronous level) |
| bp_sda_i | input | 1 | Backplane data line sample |
| bp_scl_i | input | 1 | Backplane clock line sample |
| cd_sda_i | input | 1 | Card data line sample |
| cd_scl_i | input | 1 | Card clock line sample |
| link_o | output | 1 | Closes the pass path between the two buses |
| accel_en_o | output | 1 | Enables the rise-time accelerators |
| ready_o | output | 1 | Connection established status |

## Verification
The hardest case to reach is a qualifying event that arrives while a card line is held low, followed by the card line being released. This case shows whether the controller really drops the event or connects late. To reach it, the stimulus holds one card line at 0 through a full idle window. It then releases the line while the backplane stays high, so the saturated idle count gives no second event. The bench checks that the link stays open for several more idle windows. Only after that does it deliver a STOP, which must close the link. A second case holds the card low across a STOP and then lets a later idle event complete the connection.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        ST_LOCK = 2'd0,
        ST_WAIT = 2'd1,
        ST_LINK = 2'd2
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    link;
        logic    accel;
        logic    rdy;
    } seq_reg_t;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int   W       = 4,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = d_i;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.s1 <= {W{RST_VAL}};
            r_q.s2 <= {W{RST_VAL}};
        end else begin
            r_q <= r_d;
        end
    end

    assign q_o = r_q.s2;
endmodule

// File: rtl/hs_bus_watch.sv
module hs_bus_watch #(
    parameter int IDLE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic sda_i,
    input  logic scl_i,
    output logic stop_o,
    output logic idle_o
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sda_prev;
        logic          scl_prev;
    } watch_t;

    watch_t w_d, w_q;
    logic   both_hi;

    always_comb begin
        w_d          = w_q;
        both_hi      = sda_i & scl_i;
        w_d.sda_prev = sda_i;
        w_d.scl_prev = scl_i;
        if (!run_i || !both_hi) begin
            w_d.cnt = '0;
        end else if (w_q.cnt != CW'(IDLE_CYCLES)) begin
            w_d.cnt = w_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.cnt      <= '0;
            w_q.sda_prev <= 1'b1;
            w_q.scl_prev <= 1'b1;
        end else begin
            w_q <= w_d;
        end
    end

    assign stop_o = run_i & sda_i & ~w_q.sda_prev & scl_i & w_q.scl_prev;
    assign idle_o = run_i & both_hi & (w_q.cnt == CW'(IDLE_CYCLES - 1));
endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
    import hs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pwr_good,
    input  logic    enable,
    input  logic    stop_i,
    input  logic    idle_i,
    input  logic    card_hi_i,
    output seq_st_e st_o,
    output logic    link_o,
    output logic    accel_o,
    output logic    ready_o
);
    seq_reg_t s_d, s_q;
    logic     go;

    always_comb begin
        s_d = s_q;
        go  = pwr_good & enable;
        unique case (s_q.st)
            ST_LOCK: if (go) s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (!go)                               s_d.st = ST_LOCK;
                else if ((stop_i | idle_i) && card_hi_i) s_d.st = ST_LINK;
            end
            ST_LINK: if (!go) s_d.st = ST_LOCK;
            default: s_d.st = ST_LOCK;
        endcase
        s_d.link  = (s_d.st == ST_LINK);
        s_d.accel = (s_d.st == ST_LINK);
        s_d.rdy   = s_q.link & (s_d.st == ST_LINK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st    <= ST_LOCK;
            s_q.link  <= 1'b0;
            s_q.accel <= 1'b0;
            s_q.rdy   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_o    = s_q.st;
    assign link_o  = s_q.link;
    assign accel_o = s_q.accel;
    assign ready_o = s_q.rdy;
endmodule

// File: rtl/hs_join_ctrl.sv
module hs_join_ctrl
    import hs_pkg::*;
#(
    parameter int IDLE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic enable,
    input  logic bp_sda_i,
    input  logic bp_scl_i,
    input  logic cd_sda_i,
    input  logic cd_scl_i,
    output logic link_o,
    output logic accel_en_o,
    output logic ready_o
);
    localparam int NLINES = 4;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] syn_lines;
    logic              stop_ev;
    logic              idle_ev;
    logic              card_hi;
    seq_st_e           st;

    assign raw_lines = {cd_scl_i, cd_sda_i, bp_scl_i, bp_sda_i};

    hs_sync #(.W(NLINES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_lines),
        .q_o  (syn_lines)
    );

    hs_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (st != ST_LOCK),
        .sda_i (syn_lines[0]),
        .scl_i (syn_lines[1]),
        .stop_o(stop_ev),
        .idle_o(idle_ev)
    );

    assign card_hi = syn_lines[2] & syn_lines[3];

    hs_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .enable   (enable),
        .stop_i   (stop_ev),
        .idle_i   (idle_ev),
        .card_hi_i(card_hi),
        .st_o     (st),
        .link_o   (link_o),
        .accel_o  (accel_en_o),
        .ready_o  (ready_o)
    );
endmodule

// File: rtl/hs_join_chk.sv
module hs_join_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic enable,
    input logic card_hi,
    input logic link_o,
    input logic accel_en_o,
    input logic ready_o
);
    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_good || !enable) |=> (!link_o && !accel_en_o && !ready_o));

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_o) |-> $past(pwr_good && enable));

    p_card_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_o) |-> $past(card_hi));

    p_accel_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accel_en_o == link_o);

    p_ready_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_o) |-> !ready_o);

    p_ready_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(link_o) && link_o));

    p_link_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_o && pwr_good && enable) |=> link_o);
endmodule

bind hs_join_ctrl hs_join_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .enable    (enable),
    .card_hi   (card_hi),
    .link_o    (link_o),
    .accel_en_o(accel_en_o),
    .ready_o   (ready_o)
);

// File: tb/hs_join_ctrl_bench.sv
module hs_join_ctrl_bench;
    localparam int  IDLE = 20;
    localparam time TCLK = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, enable = 1'b0;
    logic bp_sda = 1'b1, bp_scl = 1'b1, cd_sda = 1'b1, cd_scl = 1'b1;
    logic link, accel, ready;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;

    always #(TCLK/2) clk = ~clk;

    hs_join_ctrl #(.IDLE_CYCLES(IDLE)) u_hs_join_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .enable(enable),
        .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .cd_sda_i(cd_sda), .cd_scl_i(cd_scl),
        .link_o(link), .accel_en_o(accel), .ready_o(ready)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic to_lock();
        enable = 1'b0; pwr_good = 1'b1;
        bp_sda = 1'b1; bp_scl = 1'b1; cd_sda = 1'b1; cd_scl = 1'b1;
        step(4);
    endtask

    task automatic t_reset();
        step(1);
        chk("R1 link at reset", link, 1'b0);
        chk("R1 ready at reset", ready, 1'b0);
        rst_n = 1'b1;
        step(2);
        chk("R1 link after reset", link, 1'b0);
        chk("R1 accel after reset", accel, 1'b0);
    endtask

    task automatic t_lockout();
        pwr_good = 1'b0; enable = 1'b1;
        bp_sda = 1'b0; step(3); bp_sda = 1'b1;
        step(2 * IDLE);
        chk("R2 no link in lockout", link, 1'b0);
        pwr_good = 1'b1; enable = 1'b0;
        bp_sda = 1'b0; step(3); bp_sda = 1'b1;
        step(2 * IDLE);
        chk("R2 no link while disabled", link, 1'b0);
        chk("R2 accel while disabled", accel, 1'b0);
    endtask

    task automatic t_idle_connect();
        to_lock();
        enable = 1'b1;
        step(IDLE);
        chk("R4 no link before idle window", link, 1'b0);
        step(1);
        chk("R4 link on idle window", link, 1'b1);
        chk("R6 accel with link", accel, 1'b1);
        chk("R7 ready lags link", ready, 1'b0);
        step(1);
        chk("R7 ready one cycle later", ready, 1'b1);
        enable = 1'b0;
        step(1);
        chk("R8 link drops", link, 1'b0);
        chk("R8 accel drops", accel, 1'b0);
        chk("R8 ready drops", ready, 1'b0);
    endtask

    task automatic t_stop_connect();
        to_lock();
        bp_sda = 1'b0; enable = 1'b1;
        step(5);
        bp_scl = 1'b0; step(3);
        bp_sda = 1'b1; step(4);
        chk("R9 sda rise with scl low", link, 1'b0);
        bp_sda = 1'b0; step(3);
        bp_scl = 1'b1; step(3);
        chk("R9 no link before stop", link, 1'b0);
        bp_sda = 1'b1;
        step(2);
        chk("R3 no link two edges after stop", link, 1'b0);
        step(1);
        chk("R3 link three edges after stop", link, 1'b1);
        step(1);
        chk("R7 ready after stop link", ready, 1'b1);
    endtask

    task automatic t_card_low_idle();
        to_lock();
        cd_scl = 1'b0; enable = 1'b1;
        step(IDLE + 3);
        chk("R5 idle with card low", link, 1'b0);
        cd_scl = 1'b1;
        step(3 * IDLE);
        chk("R5 no late link after card release", link, 1'b0);
        bp_sda = 1'b0; step(3);
        bp_sda = 1'b1; step(3);
        chk("R5 next stop connects", link, 1'b1);
    endtask

    task automatic t_card_low_stop();
        bit seen = 1'b0;
        to_lock();
        bp_sda = 1'b0; cd_sda = 1'b0; enable = 1'b1;
        step(4);
        bp_sda = 1'b1; step(6);
        chk("R5 stop with card low", link, 1'b0);
        cd_sda = 1'b1; step(4);
        chk("R5 still waiting after release", link, 1'b0);
        for (int i = 0; i < 2 * IDLE; i++) begin
            step(1);
            if (link) seen = 1'b1;
        end
        chk("R5 later idle event connects", seen, 1'b1);
    endtask

    task automatic t_idle_restart();
        bit seen = 1'b0;
        to_lock();
        enable = 1'b1;
        step(IDLE - 5);
        bp_scl = 1'b0; step(1); bp_scl = 1'b1;
        step(6);
        chk("R4 low restarts idle count", link, 1'b0);
        for (int i = 0; i < 2 * IDLE; i++) begin
            step(1);
            if (link) seen = 1'b1;
        end
        chk("R4 connects after restarted window", seen, 1'b1);
    endtask

    task automatic t_pg_drop_wait();
        to_lock();
        enable = 1'b1;
        step(IDLE - 3);
        pwr_good = 1'b0; step(1);
        chk("R8 pg drop in wait", link, 1'b0);
        pwr_good = 1'b1;
        step(IDLE);
        chk("R8 idle count restarted", link, 1'b0);
        step(1);
        chk("R8 link after fresh window", link, 1'b1);
        step(1);
        pwr_good = 1'b0; step(1);
        chk("R8 pg drop from link", link, 1'b0);
        chk("R8 ready cleared on pg drop", ready, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lockout();
        t_idle_connect();
        t_stop_connect();
        t_card_low_idle();
        t_card_low_stop();
        t_idle_restart();
        t_pg_drop_wait();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule